// File: doc/BRIEF.md
# Per-CPU Masked Level Interrupt Aggregator

This block gathers a parameterised number of level-sensitive interrupt sources, organised as 32-bit words (at most 8 words, so up to 256 sources), and presents one parent interrupt line per CPU. Each CPU owns a private bank of registers holding its own enable state. Software reads the raw source levels and the current mask through read-only registers. It changes the mask only through two write-only registers. One of these sets mask bits and the other clears them, and each acts only on the bits written as 1.

A set mask bit disables the source for that CPU. A CPU's parent line is asserted when at least one source is both active and unmasked in that CPU's bank. The source status tracks the input level directly, so servicing an interrupt means quietening the device, not clearing a latch here. All CPU banks share one 32-bit register port. Each bank claims its own address window, which is placed directly after the previous bank's window.

Top module: `irq_fanout_ctrl`

## Requirements
- R1: After reset every mask bit of every CPU bank is 1, so every mask-readback register reads 0xFFFFFFFF and every parent output is 0.
- R2: A read of a status register returns the current level of the 32 sources in that word, in the same cycle, with source 32*w+b at bit b. Every CPU bank shows the same status.
- R3: A write to a mask-set register sets the mask bits where the write data is 1 and leaves the bits written as 0 unchanged.
- R4: A write to a mask-clear register clears the mask bits where the write data is 1 and leaves the bits written as 0 unchanged.
- R5: A mask-readback register returns the current mask word of its CPU bank, and reflects a write from the cycle after that write.
- R6: Parent output bit c is 1 exactly when, on the previous clock edge, some source in any word was 1 and its mask bit in bank c was 0. The output therefore lags its inputs by one cycle.
- R7: A mask write to one CPU bank leaves the masks of every other bank unchanged.
- R8: Writes to status registers, to mask-readback registers and to addresses outside every bank leave all masks unchanged.
- R9: Reads of mask-set and mask-clear registers, and reads of addresses outside every bank, return 0.
- R10: Bank c starts at byte address c*16*NUM_WORDS. Within a bank, the register for group g and word w is at byte offset (g*NUM_WORDS+w)*4. The groups are status (g=0), mask readback (g=1), mask set (g=2) and mask clear (g=3).
- R11: Status keeps no history. When a source drops, its status bit reads 0 and its contribution to the parent output goes away one cycle later, with no clear action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | NUM_WORDS*32 | Level interrupt sources; source n at bit n |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| cpu_irq | output | NUM_CPUS | Registered parent interrupt, one bit per CPU |

## Verification
The assertions take for granted the following conditions:
- The sources are already synchronous to the clock.
- Register accesses use word-aligned addresses.
- The bus port can deliver at most one write per cycle, so a set and a clear of the same word never coincide.

The bench drives every access and every source change a fixed delay after the rising edge, and uses only aligned addresses computed from the bank formula. It observes mask changes through the readback registers rather than through internal state.

// File: rtl/irqagg_pkg.sv
// Package: shared constants, register group encoding and mask update rule.
// Assumes mask words are exactly one source word (32 bits) wide.
package irqagg_pkg;

    localparam int SRC_PER_WORD = 32;
    localparam int MAX_WORDS    = 8;
    localparam int NUM_GROUPS   = 4;

    // Register groups inside one CPU bank, in address order.
    typedef enum logic [1:0] {
        GRP_STATUS   = 2'd0,
        GRP_MASK_RD  = 2'd1,
        GRP_MASK_SET = 2'd2,
        GRP_MASK_CLR = 2'd3
    } grp_e;

    // Next mask word: clear bits first, then set bits, so a set wins a tie.
    function automatic logic [SRC_PER_WORD-1:0] mask_next(
        input logic [SRC_PER_WORD-1:0] cur,
        input logic [SRC_PER_WORD-1:0] set_bits,
        input logic [SRC_PER_WORD-1:0] clr_bits
    );
        return (cur & ~clr_bits) | set_bits;
    endfunction

endpackage

// File: rtl/irqagg_decode.sv
// Module: irqagg_decode
// Decodes a byte address into hit / register group / word for one CPU bank.
// Assumes word-aligned accesses; address bits [1:0] are ignored.
module irqagg_decode
    import irqagg_pkg::*;
#(
    parameter int NUM_WORDS = 2,
    parameter int ADDR_W    = 8,
    parameter int BASE      = 0,
    localparam int WSEL_W   = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output grp_e              grp,
    output logic [WSEL_W-1:0] wsel
);

    localparam int BANK_BYTES = NUM_GROUPS * NUM_WORDS * 4;

    int addr_i;
    int idx;

    // Range check and split of the register index into group and word.
    always_comb begin
        addr_i = int'(32'(addr));
        hit    = (addr_i >= BASE) && (addr_i < BASE + BANK_BYTES);
        idx    = (addr_i - BASE) >>> 2;
        grp    = GRP_STATUS;
        wsel   = '0;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            if (idx >= g * NUM_WORDS && idx < (g + 1) * NUM_WORDS) begin
                grp  = grp_e'(g[1:0]);
                wsel = WSEL_W'(idx - g * NUM_WORDS);
            end
        end
    end

endmodule

// File: rtl/irqagg_bank.sv
// Module: irqagg_bank
// One CPU's register bank: mask words, read mux and registered parent line.
// Assumes irq_in is synchronous to clk and at most one write per cycle.
module irqagg_bank
    import irqagg_pkg::*;
#(
    parameter int NUM_WORDS = 2,
    parameter int ADDR_W    = 8,
    parameter int BASE      = 0,
    localparam int SRC_W    = NUM_WORDS * SRC_PER_WORD,
    localparam int WSEL_W   = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [SRC_W-1:0]        irq_in,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    we,
    input  logic [SRC_PER_WORD-1:0] wdata,
    output logic [SRC_PER_WORD-1:0] rdata,
    output logic [SRC_W-1:0]        mask_o,
    output logic                    irq_o
);

    logic              hit;
    grp_e              grp;
    logic [WSEL_W-1:0] wsel;
    logic [NUM_WORDS-1:0][SRC_PER_WORD-1:0] mask_q;

    irqagg_decode #(
        .NUM_WORDS (NUM_WORDS),
        .ADDR_W    (ADDR_W),
        .BASE      (BASE)
    ) u_decode (
        .addr (addr),
        .hit  (hit),
        .grp  (grp),
        .wsel (wsel)
    );

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        logic sel;
        assign sel = we && hit && (wsel == WSEL_W'(w));

        // Mask word w: reset to all-disabled, updated by set / clear writes.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mask_q[w] <= '1;
            end else if (sel && grp == GRP_MASK_SET) begin
                mask_q[w] <= mask_next(mask_q[w], wdata, '0);
            end else if (sel && grp == GRP_MASK_CLR) begin
                mask_q[w] <= mask_next(mask_q[w], '0, wdata);
            end
        end
    end

    assign mask_o = mask_q;

    // Read mux: status and mask readback; write-only groups read as zero.
    always_comb begin
        rdata = '0;
        if (hit) begin
            case (grp)
                GRP_STATUS:  rdata = irq_in[SRC_PER_WORD*wsel +: SRC_PER_WORD];
                GRP_MASK_RD: rdata = mask_q[wsel];
                default:     rdata = '0;
            endcase
        end
    end

    // Parent line: any active and unmasked source, registered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o <= 1'b0;
        end else begin
            irq_o <= |(irq_in & ~mask_o);
        end
    end

endmodule

// File: rtl/irq_fanout_ctrl.sv
// Module: irq_fanout_ctrl (top)
// Replicates one register bank per CPU on a shared 32-bit register port,
// each bank placed right after the previous one; read data is OR-merged
// since at most one bank hits. Assumes NUM_WORDS <= 8.
module irq_fanout_ctrl
    import irqagg_pkg::*;
#(
    parameter int NUM_WORDS = 2,
    parameter int NUM_CPUS  = 2,
    parameter int ADDR_W    = 8,
    localparam int SRC_W      = NUM_WORDS * SRC_PER_WORD,
    localparam int BANK_BYTES = NUM_GROUPS * NUM_WORDS * 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [SRC_W-1:0]        irq_in,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic                    bus_we,
    input  logic [SRC_PER_WORD-1:0] bus_wdata,
    output logic [SRC_PER_WORD-1:0] bus_rdata,
    output logic [NUM_CPUS-1:0]     cpu_irq
);

    logic [NUM_CPUS-1:0][SRC_PER_WORD-1:0] rdata_bank;
    logic [NUM_CPUS*SRC_W-1:0]             mask_all;

    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
        irqagg_bank #(
            .NUM_WORDS (NUM_WORDS),
            .ADDR_W    (ADDR_W),
            .BASE      (c * BANK_BYTES)
        ) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .irq_in (irq_in),
            .addr   (bus_addr),
            .we     (bus_we),
            .wdata  (bus_wdata),
            .rdata  (rdata_bank[c]),
            .mask_o (mask_all[c*SRC_W +: SRC_W]),
            .irq_o  (cpu_irq[c])
        );
    end

    // Read merge: banks drive zero unless addressed.
    always_comb begin
        bus_rdata = '0;
        for (int c = 0; c < NUM_CPUS; c++) begin
            bus_rdata = bus_rdata | rdata_bank[c];
        end
    end

endmodule

// File: rtl/irqagg_checker.sv
// Module: irqagg_checker
// Temporal checks on the aggregator, bound to every irq_fanout_ctrl.
// Assumes aligned addresses and synchronous sources.
module irqagg_checker
    import irqagg_pkg::*;
#(
    parameter int NUM_WORDS = 2,
    parameter int NUM_CPUS  = 2,
    parameter int ADDR_W    = 8,
    localparam int SRC_W    = NUM_WORDS * SRC_PER_WORD
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [SRC_W-1:0]        irq_in,
    input logic [ADDR_W-1:0]       bus_addr,
    input logic                    bus_we,
    input logic [SRC_PER_WORD-1:0] bus_wdata,
    input logic [SRC_PER_WORD-1:0] bus_rdata,
    input logic [NUM_CPUS-1:0]     cpu_irq,
    input logic [NUM_CPUS*SRC_W-1:0] mask_all
);

    localparam int BANK = NUM_GROUPS * NUM_WORDS * 4;

    int  a_i;
    int  grp_i;
    logic wo_or_unmapped;
    logic no_mask_effect;

    // Independent address classification from the bank formula.
    always_comb begin
        a_i            = int'(32'(bus_addr));
        grp_i          = ((a_i % BANK) / 4) / NUM_WORDS;
        wo_or_unmapped = (a_i >= NUM_CPUS * BANK) || (grp_i >= 2);
        no_mask_effect = (a_i >= NUM_CPUS * BANK) || (grp_i <= 1);
    end

    assert_wo_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wo_or_unmapped |-> bus_rdata == '0);

    assert_ro_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && no_mask_effect) |=> $stable(mask_all));

    assert_quiet_sources_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(|irq_in) |-> cpu_irq == '0);

    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_c
        for (genvar w = 0; w < NUM_WORDS; w++) begin : g_w
            localparam int A_SET = c * BANK + (2 * NUM_WORDS + w) * 4;
            localparam int A_CLR = c * BANK + (3 * NUM_WORDS + w) * 4;
            logic [SRC_PER_WORD-1:0] mword;
            assign mword = mask_all[(c*NUM_WORDS + w)*SRC_PER_WORD +: SRC_PER_WORD];

            assert_set_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (bus_we && a_i == A_SET) |=> (mword & $past(bus_wdata)) == $past(bus_wdata));

            assert_clr_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (bus_we && a_i == A_CLR) |=> (mword & $past(bus_wdata)) == '0);
        end
    end

endmodule

bind irq_fanout_ctrl irqagg_checker #(
    .NUM_WORDS (NUM_WORDS),
    .NUM_CPUS  (NUM_CPUS),
    .ADDR_W    (ADDR_W)
) u_irqagg_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_in    (irq_in),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cpu_irq   (cpu_irq),
    .mask_all  (mask_all)
);

// File: tb/test_irq_fanout_ctrl.sv
// Scoreboard bench: driver tasks queue expectations, a monitor compares them.
module test_irq_fanout_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NW   = 2;
    localparam int NC   = 2;
    localparam int AW   = 8;
    localparam int BANK = 16 * NW;

    logic            clk;
    logic            rst_n;
    logic [NW*32-1:0] irq_in;
    logic [AW-1:0]   bus_addr;
    logic            bus_we;
    logic [31:0]     bus_wdata;
    logic [31:0]     bus_rdata;
    logic [NC-1:0]   cpu_irq;

    irq_fanout_ctrl #(.NUM_WORDS(NW), .NUM_CPUS(NC), .ADDR_W(AW)) i_irq_fanout_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cpu_irq(cpu_irq)
    );

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sbq[$];
    logic  chk;
    int    total = 0;
    int    bad   = 0;
    bit    done  = 0;

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    // Monitor: compare queued expectation with the port value at the falling edge.
    always @(negedge clk) begin
        item_t       it;
        logic [31:0] act;
        if (chk === 1'b1 && sbq.size() > 0) begin
            it  = sbq.pop_front();
            act = it.is_irq ? 32'(cpu_irq) : bus_rdata;
            total++;
            if (act !== it.exp) begin
                bad++;
                $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    function automatic int ra(int c, int g, int w);
        return c * BANK + (g * NW + w) * 4;
    endfunction

    task automatic idle();
        @(posedge clk); #1;
        bus_we = 1'b0; chk = 1'b0;
    endtask

    task automatic wr(int a, logic [31:0] d);
        @(posedge clk); #1;
        chk = 1'b0; bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    endtask

    task automatic rd(int a, logic [31:0] e, string tag);
        @(posedge clk); #1;
        bus_we = 1'b0; bus_addr = AW'(a);
        sbq.push_back('{1'b0, e, tag}); chk = 1'b1;
    endtask

    task automatic irq_chk(logic [NC-1:0] e, string tag);
        @(posedge clk); #1;
        bus_we = 1'b0;
        sbq.push_back('{1'b1, 32'(e), tag}); chk = 1'b1;
    endtask

    task automatic set_irq(logic [NW*32-1:0] v);
        @(posedge clk); #1;
        bus_we = 1'b0; chk = 1'b0; irq_in = v;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; irq_in = '0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0; chk = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(ra(0,1,0), 32'hFFFF_FFFF, "R1 mask c0w0");
        rd(ra(0,1,1), 32'hFFFF_FFFF, "R1 mask c0w1");
        rd(ra(1,1,0), 32'hFFFF_FFFF, "R1 mask c1w0");
        rd(ra(1,1,1), 32'hFFFF_FFFF, "R1 mask c1w1");
        irq_chk(2'b00, "R1 parent low");

        // R2 / R10 status by address
        set_irq({32'h8000_0000, 32'h0000_0011});
        rd(ra(0,0,0), 32'h0000_0011, "R2 status c0w0");
        rd(ra(0,0,1), 32'h8000_0000, "R10 status c0w1");
        rd(ra(1,0,1), 32'h8000_0000, "R2 status c1w1");
        irq_chk(2'b00, "R1 all masked");

        // R4 clear, R7 isolation, R6 parent
        wr(ra(0,3,0), 32'h0000_0001);
        rd(ra(0,1,0), 32'hFFFF_FFFE, "R4 clear bit0");
        rd(ra(1,1,0), 32'hFFFF_FFFF, "R7 other bank");
        irq_chk(2'b01, "R6 cpu0 pending");

        // R3 set / R5 readback
        wr(ra(0,2,0), 32'h0000_0100);
        rd(ra(0,1,0), 32'hFFFF_FFFE, "R3 set already-set");
        wr(ra(0,3,0), 32'h0000_00F0);
        rd(ra(0,1,0), 32'hFFFF_FF0E, "R4 clear nibble");
        wr(ra(0,2,0), 32'h0000_0010);
        rd(ra(0,1,0), 32'hFFFF_FF1E, "R5 readback after set");

        // R9 write-only and unmapped reads
        rd(ra(0,2,0), 32'h0, "R9 set reg reads 0");
        rd(ra(1,3,1), 32'h0, "R9 clr reg reads 0");
        rd(8'hF0, 32'h0, "R9 unmapped reads 0");

        // R8 ignored writes
        wr(ra(0,0,0), 32'hFFFF_FFFF);
        wr(ra(0,1,0), 32'h0000_0000);
        wr(8'hF0, 32'hFFFF_FFFF);
        rd(ra(0,1,0), 32'hFFFF_FF1E, "R8 mask c0w0 kept");
        rd(ra(1,1,0), 32'hFFFF_FFFF, "R8 mask c1w0 kept");

        // R11 level following
        set_irq({32'h8000_0000, 32'h0000_0010});
        irq_chk(2'b00, "R11 source dropped");
        rd(ra(0,0,0), 32'h0000_0010, "R11 status follows");
        set_irq({32'h8000_0000, 32'h0000_0011});
        irq_chk(2'b01, "R11 source back");

        // R6 word1 to cpu1, R7 cpu0 word1 untouched
        wr(ra(1,3,1), 32'h8000_0000);
        rd(ra(1,1,1), 32'h7FFF_FFFF, "R4 c1w1 clear");
        irq_chk(2'b11, "R6 both pending");
        rd(ra(0,1,1), 32'hFFFF_FFFF, "R7 c0w1 kept");

        // R3 re-mask drops cpu0
        wr(ra(0,2,0), 32'h0000_0001);
        rd(ra(0,1,0), 32'hFFFF_FF1F, "R3 set bit0");
        irq_chk(2'b10, "R3 cpu0 masked");

        set_irq('0);
        irq_chk(2'b00, "R11 all quiet");
        idle();
        idle();

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule